// File: doc/BRIEF.md
# AVI Infoframe Byte Generator

This block builds the 17-byte auxiliary video information frame that accompanies a video mode on a digital display link, and hands it out as a byte stream. A single-cycle start pulse samples three mode inputs: pixel clock in kHz, active width and active height. From these the block derives one mode-dependent field byte. That byte carries the colorimetry choice (standard or high definition) and the picture aspect choice (4:3 or 16:9). The block then computes the checksum over the finished frame.

The frame leaves on a valid/ready byte interface, one byte per accepted transfer, with the byte position on a separate index output and a last flag on the final byte. The consumer may hold ready low for any number of cycles. The byte, index and last flag then stay frozen until the transfer is taken. Back-pressure never drops or reorders bytes. The start pulse and mode inputs are plain control pins. A start that arrives while a frame is still going out is ignored.

Top module: `avi_infoframe_gen`

## Requirements
- R1: The frame bytes by index are: 0 = 0x82, 1 = 0x02, 2 = 0x0D, 3 = checksum, 4 = 0x12, 5 = mode field, 6 = 0x88, 7 to 16 = 0x00.
- R2: Bits 7:6 of the mode field (index 5) are 01 (0x40) when the sampled pixel clock is at most 27000 kHz, and 10 (0x80) otherwise.
- R3: Bits 5:3 of the mode field are 011 (0x18, 4:3) when width*100 < 156*height, and 101 (0x28, 16:9) otherwise, including a height of zero.
- R4: The checksum byte at index 3 makes the 8-bit sum of all 17 bytes equal to zero. It is formed with the mode field already in place and the checksum position counted as zero.
- R5: The cycle after a start is accepted, out_valid is high with index 0. Indices then advance 0 to 16 by one per accepted transfer, out_last is high only with index 16, and out_valid is low in the cycle after the index-16 transfer.
- R6: While out_valid is high and out_ready is low, out_data, out_index and out_last keep their values in the next cycle and out_valid stays high.
- R7: Start and mode inputs are sampled only when no frame is being sent. A start pulse or changed mode inputs during a frame do not change any byte of that frame or cut it short.
- R8: After reset, out_valid is low and out_index is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Single-cycle request to build and send a frame |
| pix_clk_khz | input | PCLK_W (20) | Pixel clock in kHz, sampled at an accepted start |
| act_width | input | RES_W (12) | Active pixels per line, sampled at an accepted start |
| act_height | input | RES_W (12) | Active lines per picture, sampled at an accepted start |
| out_ready | input | 1 | Consumer can take the current byte |
| out_valid | output | 1 | A frame byte is presented |
| out_data | output | 8 | Frame byte |
| out_index | output | 5 | Position of out_data within the frame |
| out_last | output | 1 | High with the final byte (index 16) |

## Verification
The assertions assume that out_ready is a plain level the consumer may change on any cycle. They assume that start may be asserted at any time, including in the cycle of the last transfer, and that mode inputs may change freely while a frame is in flight. The stimulus is built to cover those cases. It mixes runs with ready held high and runs with irregular ready stalls. On some frames it raises start and changes all mode inputs partway through the frame. Mode values are swept around the 27000 kHz colorimetry limit and on both sides of the 1.56 aspect threshold, for heights from zero to the full input range.

// File: rtl/avi_frame_pkg.sv
package avi_frame_pkg;
  localparam int unsigned FRAME_LEN = 17;
  localparam int unsigned IDX_W     = $clog2(FRAME_LEN);
  localparam int unsigned CSUM_POS  = 3;
  localparam int unsigned FIELD_POS = 5;
  localparam int unsigned LAST_POS  = FRAME_LEN - 1;

  typedef enum logic {ST_IDLE, ST_SEND} send_state_e;

  // Fixed content of the frame; the checksum and field positions read as zero.
  function automatic logic [7:0] base_byte(input logic [IDX_W-1:0] idx);
    case (idx)
      IDX_W'(0): return 8'h82;
      IDX_W'(1): return 8'h02;
      IDX_W'(2): return 8'h0D;
      IDX_W'(4): return 8'h12;
      IDX_W'(6): return 8'h88;
      default:   return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/avi_field_calc.sv
module avi_field_calc #(
  parameter int unsigned PCLK_W       = 20,
  parameter int unsigned RES_W        = 12,
  parameter int unsigned SD_LIMIT_KHZ = 27000,
  parameter int unsigned RATIO_X100   = 156
) (
  input  logic [PCLK_W-1:0] pix_clk_khz,
  input  logic [RES_W-1:0]  act_width,
  input  logic [RES_W-1:0]  act_height,
  output logic [7:0]        field_byte
);
  localparam int unsigned PROD_W = RES_W + 8;

  logic [PROD_W-1:0] width_scaled;
  logic [PROD_W-1:0] height_scaled;
  logic              is_sd;
  logic              is_narrow;

  always_comb begin
    width_scaled  = PROD_W'(act_width)  * PROD_W'(100);
    height_scaled = PROD_W'(act_height) * PROD_W'(RATIO_X100);
    is_sd         = (pix_clk_khz <= PCLK_W'(SD_LIMIT_KHZ));
    is_narrow     = (width_scaled < height_scaled);
    field_byte    = (is_sd ? 8'h40 : 8'h80) | (is_narrow ? 8'h18 : 8'h28);
  end
endmodule

// File: rtl/avi_checksum.sv
module avi_checksum
  import avi_frame_pkg::*;
(
  input  logic [7:0] field_byte,
  output logic [7:0] csum_byte
);
  logic [7:0] term [FRAME_LEN];

  for (genvar g = 0; g < FRAME_LEN; g++) begin : g_term
    if (g == FIELD_POS) begin : g_field
      assign term[g] = field_byte;
    end else if (g == CSUM_POS) begin : g_hole
      assign term[g] = 8'h00;
    end else begin : g_fixed
      assign term[g] = base_byte(IDX_W'(g));
    end
  end

  logic [7:0] acc;
  always_comb begin
    acc = 8'h00;
    for (int i = 0; i < FRAME_LEN; i++) acc = acc + term[i];
    csum_byte = 8'h00 - acc;
  end
endmodule

// File: rtl/avi_byte_stream.sv
module avi_byte_stream
  import avi_frame_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [7:0]       field_in,
  input  logic [7:0]       csum_in,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [7:0]       out_data,
  output logic [IDX_W-1:0] out_index,
  output logic             out_last
);
  send_state_e      state_q;
  logic [IDX_W-1:0] idx_q;
  logic [7:0]       field_q;
  logic [7:0]       csum_q;
  logic             at_end;
  logic             xfer;

  assign at_end = (idx_q == IDX_W'(LAST_POS));
  assign xfer   = (state_q == ST_SEND) && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      field_q <= '0;
      csum_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q <= ST_SEND;
            idx_q   <= '0;
            field_q <= field_in;
            csum_q  <= csum_in;
          end
        end
        ST_SEND: begin
          if (xfer) begin
            if (at_end) begin
              state_q <= ST_IDLE;
              idx_q   <= '0;
            end else begin
              idx_q <= idx_q + IDX_W'(1);
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    out_valid = (state_q == ST_SEND);
    out_index = idx_q;
    out_last  = out_valid && at_end;
    if (idx_q == IDX_W'(CSUM_POS))       out_data = csum_q;
    else if (idx_q == IDX_W'(FIELD_POS)) out_data = field_q;
    else                                 out_data = base_byte(idx_q);
  end
endmodule

// File: rtl/avi_infoframe_gen.sv
module avi_infoframe_gen
  import avi_frame_pkg::*;
#(
  parameter int unsigned PCLK_W       = 20,
  parameter int unsigned RES_W        = 12,
  parameter int unsigned SD_LIMIT_KHZ = 27000,
  parameter int unsigned RATIO_X100   = 156
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PCLK_W-1:0] pix_clk_khz,
  input  logic [RES_W-1:0]  act_width,
  input  logic [RES_W-1:0]  act_height,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [7:0]        out_data,
  output logic [IDX_W-1:0]  out_index,
  output logic              out_last
);
  logic [7:0] field_w;
  logic [7:0] csum_w;

  avi_field_calc #(
    .PCLK_W(PCLK_W), .RES_W(RES_W),
    .SD_LIMIT_KHZ(SD_LIMIT_KHZ), .RATIO_X100(RATIO_X100)
  ) u_field (
    .pix_clk_khz(pix_clk_khz),
    .act_width  (act_width),
    .act_height (act_height),
    .field_byte (field_w)
  );

  avi_checksum u_csum (
    .field_byte(field_w),
    .csum_byte (csum_w)
  );

  avi_byte_stream u_stream (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .field_in (field_w),
    .csum_in  (csum_w),
    .out_ready(out_ready),
    .out_valid(out_valid),
    .out_data (out_data),
    .out_index(out_index),
    .out_last (out_last)
  );
endmodule

// File: rtl/avi_infoframe_sva.sv
module avi_infoframe_sva
  import avi_frame_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             out_ready,
  input logic             out_valid,
  input logic [7:0]       out_data,
  input logic [IDX_W-1:0] out_index,
  input logic             out_last
);
  logic [7:0] run_sum;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_sum <= 8'h00;
    else if (out_valid && out_ready) run_sum <= out_last ? 8'h00 : run_sum + out_data;
  end

  p_header_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_index == IDX_W'(0) |-> out_data == 8'h82);

  p_sum_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |-> (run_sum + out_data) == 8'h00);

  p_last_pos_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid && out_index == IDX_W'(LAST_POS));

  p_first_idx_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> out_index == IDX_W'(0));

  p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !out_last |=> out_valid && out_index == $past(out_index) + IDX_W'(1));

  p_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> !out_valid);

  p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_index) && $stable(out_last));

  p_start_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && start && !out_last |=> out_valid);
endmodule

bind avi_infoframe_gen avi_infoframe_sva u_sva (
  .clk(clk), .rst_n(rst_n), .start(start), .out_ready(out_ready),
  .out_valid(out_valid), .out_data(out_data), .out_index(out_index), .out_last(out_last)
);

// File: tb/tb_avi_infoframe_gen.sv
module tb_avi_infoframe_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [19:0] pix_clk_khz = '0;
  logic [11:0] act_width = '0;
  logic [11:0] act_height = '0;
  logic        out_ready = 1'b0;
  logic        out_valid;
  logic [7:0]  out_data;
  logic [4:0]  out_index;
  logic        out_last;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc++;

  avi_infoframe_gen dut (
    .clk(clk), .rst_n(rst_n), .start(start), .pix_clk_khz(pix_clk_khz),
    .act_width(act_width), .act_height(act_height), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data), .out_index(out_index), .out_last(out_last)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic run_frame(input int pclk, input int h, input int v, input bit disturb, input int pat);
    int exp [17];
    int b5, sum, idx, guard, prev_d, prev_i;
    bit stalled;
    b5 = (pclk <= 27000) ? 'h40 : 'h80;
    b5 |= (v != 0 && (h * 100) / v < 156) ? 'h18 : 'h28;
    exp = '{'h82, 'h02, 'h0D, 0, 'h12, b5, 'h88, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0};
    sum = 0;
    for (int i = 0; i < 17; i++) sum += exp[i];
    exp[3] = (256 - (sum % 256)) % 256;

    @(negedge clk);
    start = 1'b1; pix_clk_khz = 20'(pclk); act_width = 12'(h); act_height = 12'(v);
    @(negedge clk);
    start = 1'b0;
    #1;
    check(out_valid && out_index == 0, "R5 first byte", {out_valid, out_index}, 'h20);
    idx = 0; guard = 0; stalled = 0; prev_d = 0; prev_i = 0;
    while (idx < 17 && guard < 400) begin
      guard++;
      out_ready = (pat == 0) ? 1'b1 : (((guard * 7 + pat) % 3) != 0);
      check(out_valid, disturb ? "R7 frame kept" : "R5 valid held", out_valid, 1);
      if (stalled)
        check(out_data == prev_d && out_index == prev_i, "R6 stall hold",
              {out_index, out_data}, {prev_i[4:0], prev_d[7:0]});
      check(out_index == idx, "R5 index", out_index, idx);
      check(out_last == (idx == 16), "R5 last", out_last, idx == 16);
      if (out_ready)
        check(out_data == exp[idx],
              idx == 3 ? "R4 checksum" : idx == 5 ? "R2 R3 field" : disturb ? "R7 byte" : "R1 byte",
              out_data, exp[idx]);
      stalled = !out_ready; prev_d = out_data; prev_i = out_index;
      if (out_ready) idx++;
      if (disturb && idx == 2) begin
        start = 1'b1; pix_clk_khz = 20'(pclk ^ 'h5A5A5); act_width = 12'(~h); act_height = 12'(v + 7);
      end
      @(negedge clk);
      start = 1'b0;
      #1;
    end
    check(idx == 17, "R5 frame length", idx, 17);
    check(!out_valid, "R5 idle after last", out_valid, 0);
    out_ready = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      check(0, "watchdog", cyc, 0);
      finish_run();
    end
  end

  initial begin
    int vlist [9];
    int plist [5];
    int hc, h;
    int n;
    vlist = '{0, 1, 3, 25, 100, 480, 720, 1080, 4095};
    plist = '{0, 26999, 27000, 27001, 1048575};
    repeat (3) @(negedge clk);
    #1;
    check(!out_valid && out_index == 0, "R8 reset", {out_valid, out_index}, 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(!out_valid, "R8 idle", out_valid, 0);
    n = 0;
    foreach (plist[p]) begin
      foreach (vlist[k]) begin
        hc = (156 * vlist[k] + 99) / 100;
        for (int j = 0; j < 5; j++) begin
          case (j)
            0: h = hc - 1;
            1: h = hc;
            2: h = hc + 1;
            3: h = 0;
            default: h = 4095;
          endcase
          if (h < 0) h = 0;
          if (h > 4095) h = 4095;
          run_frame(plist[p], h, vlist[k], (n % 4) == 3, n % 3);
          n++;
        end
      end
    end
    done = 1;
    finish_run();
  end
endmodule